// File: doc/BRIEF.md
# Comma-Aligned Serial Deserializer

This block takes a retimed serial stream, one bit per cycle of the bit-rate clock, and rebuilds 10-bit characters from it. It looks for the positive-disparity comma and places the character boundary so that the comma's first-arrived bit lands in character bit 0. Each character leaves the block as two 5-bit halves on a narrow bus. Two byte-clock outputs, both registered in the bit-clock domain, mark the halves: one rises when the low half appears and the other rises five bit times later, when the high half appears.

When a comma shows up off the current boundary, the character counter moves to the new boundary at once. The byte-clock phase counter does not jump. It pauses, which lengthens the current byte-clock phase until it falls back in step with the new boundary, so no high or low phase is ever cut short. A loopback select chooses either the external serial input or the transmit-side serial stream as the bit source.

Top module: `comma_deser`

## Requirements
- R1: A synchronous active-high reset clears the window, counters and lock state. From the first clock edge with reset high, `rx_half`, `bclk_lo`, `bclk_hi` and `locked` are all 0.
- R2: Until the first comma is seen, `locked`, `rx_half`, `bclk_lo` and `bclk_hi` stay 0.
- R3: A comma is any 10-bit window whose seven earliest-arrived bits are 0,0,1,1,1,1,1 in arrival order. The three latest bits are ignored. A window of 0,0,1,1,1,1,0 followed by any three bits is not a comma.
- R4: On the clock edge that takes in the tenth bit of the first comma, `locked` becomes 1, `bclk_lo` becomes 1, and `rx_half` shows character bits 0..4, with the first-arrived bit in `rx_half[0]`.
- R5: While locked, `bclk_hi` is the complement of `bclk_lo`. In steady state `bclk_lo` is high for 5 cycles and then low for 5. At each rise of `bclk_hi`, `rx_half[k]` shows character bit 5+k.
- R6: A comma that ends exactly on the current boundary causes no realignment and no change to byte-clock timing. Every phase stays 5 cycles long.
- R7: On realignment the byte-clock phases are only ever lengthened. Each completed phase of `bclk_lo` after lock lasts at least 5 and at most 14 cycles.
- R8: After a realigning comma, the next comma on the new boundary appears on `rx_half` (value 5'b11100) on the same edge that `bclk_lo` rises.
- R9: When `loop_en` is 1 the bit source is `tx_loop_ser`. When it is 0 the bit source is `ser_in`.
- R10: Commas in consecutive characters, on or off the boundary, never clear `locked`.
- R11: `rx_half` changes only on an edge where `bclk_lo` or `bclk_hi` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | External retimed serial bit |
| tx_loop_ser | input | 1 | Transmit-side serial bit used for loopback |
| loop_en | input | 1 | 1 selects `tx_loop_ser`, 0 selects `ser_in` |
| rx_half | output | 5 | Current 5-bit half of the recovered character |
| bclk_lo | output | 1 | Byte clock that rises with the low half |
| bclk_hi | output | 1 | Byte clock that rises with the high half |
| locked | output | 1 | Set once the first comma has been found |

## Verification
Two functions can fall in the same cycle: a realignment request and a stretch that is still running from the previous one. The bench provokes this by slipping the stream by a few bits and then sending commas back to back, so the second comma arrives while the phase counter is still paused. A second collision, a comma landing exactly on the current boundary, is provoked by sending commas at the normal character spacing. Both cases are judged against a behavioural per-cycle model, and independently by measuring every byte-clock phase length and every change of `rx_half` at the ports.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;

    localparam int CHAR_W  = 10;
    localparam int HALF_W  = CHAR_W / 2;
    localparam int CNT_W   = $clog2(CHAR_W);
    localparam int HEAD_W  = 7;
    localparam int MAX_RUN = CHAR_W + HALF_W - 1;
    localparam int RUN_W   = $clog2(MAX_RUN + 2) + 1;

    // earliest-arrived bit sits in bit 0 of the window
    localparam logic [HEAD_W-1:0] COMMA_HEAD = 7'b1111100;

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam cnt_t SLOT_LAST = cnt_t'(CHAR_W - 1);
    localparam cnt_t SLOT_HALF = cnt_t'(HALF_W);

    typedef enum logic {
        PH_HUNT = 1'b0,
        PH_LOCK = 1'b1
    } lock_e;

    // what the framer hands to the byte-clock stage each cycle
    typedef struct packed {
        logic  lock_now;
        logic  locked;
        cnt_t  slot;
        char_t hold_nx;
    } frame_t;

    function automatic cnt_t slot_inc(cnt_t c);
        if (c == SLOT_LAST) return '0;
        return c + cnt_t'(1);
    endfunction

    function automatic logic is_comma(char_t w);
        return w[HEAD_W-1:0] == COMMA_HEAD;
    endfunction

endpackage

// File: rtl/cd_input_sel.sv
module cd_input_sel (
    input  logic ext_bit,
    input  logic loop_bit,
    input  logic use_loop,
    output logic sel_bit
);
    always_comb begin
        sel_bit = use_loop ? loop_bit : ext_bit;
    end
endmodule

// File: rtl/cd_window.sv
module cd_window
    import comma_deser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_in,
    output char_t win_nx,
    output logic  hit
);
    char_t win;

    always_comb begin
        win_nx = {bit_in, win[CHAR_W-1:1]};
        hit    = is_comma(win_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) win <= '0;
        else     win <= win_nx;
    end
endmodule

// File: rtl/cd_framer.sv
module cd_framer
    import comma_deser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  char_t  win_nx,
    output frame_t fr
);
    lock_e st;
    cnt_t  slot;
    cnt_t  slot_nx;
    char_t hold;
    char_t hold_nx;
    logic  lock_now;
    logic  char_end;

    always_comb begin
        lock_now = (st == PH_HUNT) && hit;
        char_end = (st == PH_LOCK) && (hit || slot == SLOT_LAST);
        if (lock_now || char_end)
            slot_nx = '0;
        else if (st == PH_LOCK)
            slot_nx = slot_inc(slot);
        else
            slot_nx = slot;
        hold_nx = (lock_now || char_end) ? win_nx : hold;
        fr = '{lock_now: lock_now, locked: (st == PH_LOCK), slot: slot, hold_nx: hold_nx};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PH_HUNT;
            slot <= '0;
            hold <= '0;
        end else begin
            if (lock_now) st <= PH_LOCK;
            slot <= slot_nx;
            hold <= hold_nx;
        end
    end

    // R10: lock is never dropped once gained
    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (st == PH_LOCK) |=> (st == PH_LOCK));
endmodule

// File: rtl/cd_byteclk.sv
module cd_byteclk
    import comma_deser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  frame_t fr,
    output half_t  rxd,
    output logic   clk_lo,
    output logic   clk_hi
);
    cnt_t  pc;
    cnt_t  pc_nx;
    char_t och;
    logic  adv;
    logic  run_nx;

    // phase counter only steps while in step with the framer slot,
    // otherwise it pauses, which lengthens the current phase
    always_comb begin
        run_nx = fr.locked || fr.lock_now;
        if (fr.lock_now) begin
            pc_nx = '0;
            adv   = 1'b1;
        end else if (fr.locked && pc == fr.slot) begin
            pc_nx = slot_inc(pc);
            adv   = 1'b1;
        end else begin
            pc_nx = pc;
            adv   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            och    <= '0;
            rxd    <= '0;
            clk_lo <= 1'b0;
            clk_hi <= 1'b0;
        end else begin
            pc     <= pc_nx;
            clk_lo <= run_nx && (pc_nx < SLOT_HALF);
            clk_hi <= run_nx && !(pc_nx < SLOT_HALF);
            if (adv && pc_nx == '0) begin
                och <= fr.hold_nx;
                rxd <= fr.hold_nx[HALF_W-1:0];
            end else if (adv && pc_nx == SLOT_HALF) begin
                rxd <= och[CHAR_W-1:HALF_W];
            end
        end
    end

    // run-length observer for the phase-length properties
    logic [RUN_W-1:0] seg;
    logic             lo_d;
    logic             armed;
    logic             chg;

    always_comb chg = (clk_lo != lo_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg   <= '0;
            lo_d  <= 1'b0;
            armed <= 1'b0;
        end else begin
            lo_d <= clk_lo;
            if (chg) begin
                seg   <= RUN_W'(1);
                armed <= 1'b1;
            end else if (seg != '1) begin
                seg <= seg + RUN_W'(1);
            end
        end
    end

    p_min_phase_r7: assert property (@(posedge clk) disable iff (rst)
        (chg && armed) |-> (seg >= RUN_W'(HALF_W)));

    p_max_phase_r7: assert property (@(posedge clk) disable iff (rst)
        (chg && armed) |-> (seg <= RUN_W'(MAX_RUN)));

    p_half_on_edge_r11: assert property (@(posedge clk) disable iff (rst)
        (!$rose(clk_lo) && !$rose(clk_hi)) |-> $stable(rxd));
endmodule

// File: rtl/comma_deser.sv
module comma_deser
    import comma_deser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              tx_loop_ser,
    input  logic              loop_en,
    output logic [HALF_W-1:0] rx_half,
    output logic              bclk_lo,
    output logic              bclk_hi,
    output logic              locked
);
    logic   sel_bit;
    char_t  win_nx;
    logic   hit;
    frame_t fr;

    cd_input_sel u_sel (
        .ext_bit  (ser_in),
        .loop_bit (tx_loop_ser),
        .use_loop (loop_en),
        .sel_bit  (sel_bit)
    );

    cd_window u_win (
        .clk    (clk),
        .rst    (rst),
        .bit_in (sel_bit),
        .win_nx (win_nx),
        .hit    (hit)
    );

    cd_framer u_frm (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .win_nx (win_nx),
        .fr     (fr)
    );

    cd_byteclk u_bck (
        .clk    (clk),
        .rst    (rst),
        .fr     (fr),
        .rxd    (rx_half),
        .clk_lo (bclk_lo),
        .clk_hi (bclk_hi)
    );

    always_comb locked = fr.locked;

    // R2: outputs quiet while hunting
    p_hunt_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (rx_half == '0 && !bclk_lo && !bclk_hi));
endmodule

// File: tb/comma_deser_test.sv
module comma_deser_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       tx_loop_ser = 1'b0;
    logic       loop_en = 1'b0;
    logic [4:0] rx_half;
    logic       bclk_lo, bclk_hi, locked;

    comma_deser uut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .tx_loop_ser(tx_loop_ser),
        .loop_en(loop_en), .rx_half(rx_half), .bclk_lo(bclk_lo),
        .bclk_hi(bclk_hi), .locked(locked)
    );

    always #10 clk = ~clk;

    localparam logic [9:0] K_POS = 10'b0101111100;
    localparam logic [9:0] K_ALT = 10'b1011111100;
    localparam logic [9:0] NEAR  = 10'b0100111100;
    localparam logic [9:0] D1    = 10'b1010101010;
    localparam logic [9:0] D2    = 10'b0110100110;
    localparam logic [9:0] D3    = 10'b1001011001;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [9:0] mw = '0, m_hold = '0, m_och = '0;
    logic [4:0] e_rxd = '0;
    bit e_a = 0, e_b = 0, m_lock = 0, started = 0;
    int ms = 0, mp = 0;

    always @(posedge clk) begin
        bit b, hit, step;
        b = loop_en ? tx_loop_ser : ser_in;
        started = 1;
        if (rst) begin
            mw = '0; m_hold = '0; m_och = '0; e_rxd = '0;
            e_a = 0; e_b = 0; m_lock = 0; ms = 0; mp = 0;
        end else begin
            mw  = {b, mw[9:1]};
            hit = (mw[6:0] == 7'b1111100);
            if (!m_lock) begin
                if (hit) begin
                    m_lock = 1; ms = 0; mp = 0; m_hold = mw; m_och = mw;
                    e_rxd = mw[4:0]; e_a = 1; e_b = 0;
                end
            end else begin
                step = (mp == ms);
                if (hit || ms == 9) begin m_hold = mw; ms = 0; end
                else ms = (ms + 1) % 10;
                if (step) begin
                    mp = (mp + 1) % 10;
                    if (mp == 0) begin m_och = m_hold; e_rxd = m_hold[4:0]; end
                    else if (mp == 5) e_rxd = m_och[9:5];
                end
                e_a = (mp < 5); e_b = !e_a;
            end
        end
    end

    // ---------------- per-cycle comparison and port monitors ----------------
    int  run = 0, rmin = 1000, rmax = 0;
    bit  armed = 0, pa = 0, pb = 0;
    logic [4:0] prx = '0;
    int  v11 = 0, v5 = 0;

    task automatic clear_runs();
        rmin = 1000; rmax = 0;
    endtask

    task automatic clear_mon();
        armed = 0; run = 0; pa = 0; pb = 0; prx = '0; clear_runs();
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk({rx_half, bclk_lo, bclk_hi, locked} == {e_rxd, e_a, e_b, m_lock},
                "R5 per-cycle model", {rx_half, bclk_lo, bclk_hi, locked},
                {e_rxd, e_a, e_b, m_lock});
            if (locked) begin
                if (bclk_lo == pa) run++;
                else begin
                    if (armed) begin
                        if (run < rmin) rmin = run;
                        if (run > rmax) rmax = run;
                    end
                    armed = 1; run = 1;
                end
                if (bclk_hi == bclk_lo) v5++;
            end
            if (rx_half != prx && !(bclk_lo && !pa) && !(bclk_hi && !pb)) v11++;
            pa = bclk_lo; pb = bclk_hi; prx = rx_half;
        end
    end

    // ---------------- stimulus ----------------
    bit via_tx = 0;
    bit noise  = 0;

    task automatic send_bit(input logic b);
        @(negedge clk);
        noise = !noise;
        if (via_tx) begin tx_loop_ser = b; ser_in = noise; end
        else        begin ser_in = b; tx_loop_ser = noise; end
    endtask

    task automatic send_char(input logic [9:0] c);
        for (int i = 0; i < 10; i++) send_bit(c[i]);
    endtask

    task automatic settle();
        @(posedge clk); #2;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        chk(rx_half == 0 && !bclk_lo && !bclk_hi && !locked, "R1 reset state",
            {rx_half, bclk_lo, bclk_hi, locked}, 0);
        rst = 0;
        clear_mon();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rx_half == 0 && !bclk_lo && !bclk_hi && !locked, "R1 initial reset",
            {rx_half, bclk_lo, bclk_hi, locked}, 0);
        rst = 0;
        clear_mon();

        // R2: hunting with data only
        send_char(D1); send_char(D2); send_char(D3);
        settle();
        chk(!locked && rx_half == 0, "R2 hunting quiet", {locked, rx_half}, 0);

        // R3: near-miss head must not lock
        send_char(NEAR); send_char(D1);
        settle();
        chk(!locked, "R3 near-miss ignored", locked, 0);

        // R4: first comma
        send_char(K_POS);
        settle();
        chk(locked && bclk_lo && !bclk_hi && rx_half == 5'b11100, "R4 first comma",
            {locked, bclk_lo, bclk_hi, rx_half}, {3'b110, 5'b11100});

        // R6: commas on the current boundary
        clear_runs();
        send_char(D1); send_char(D2); send_char(K_POS); send_char(D3);
        send_char(K_POS); send_char(D1);
        settle();
        chk(rmin == 5 && rmax == 5, "R6 boundary comma keeps timing", rmax, 5);

        // R7/R8: slip then realign
        clear_runs();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_char(K_POS); send_char(D2); send_char(K_POS);
        settle();
        chk(bclk_lo && !bclk_hi && rx_half == 5'b11100, "R8 realigned comma",
            {bclk_lo, bclk_hi, rx_half}, {2'b10, 5'b11100});
        chk(rmin >= 5, "R7 no short phase", rmin, 5);
        chk(rmax <= 14 && rmax > 5, "R7 stretched phase bounded", rmax, 14);

        // R10: slip then back-to-back commas, comma during a stretch
        clear_runs();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_char(K_POS); send_char(K_POS); send_char(K_POS);
        send_char(D1); send_char(D3);
        settle();
        chk(locked, "R10 lock kept over consecutive commas", locked, 1);
        chk(rmin >= 5 && rmax <= 14, "R7 phases within bounds after collision", rmin, 5);
        chk(v11 == 0, "R11 half changes only at byte-clock rise", v11, 0);
        chk(v5 == 0, "R5 byte clocks complementary", v5, 0);

        // R1 again mid-run, then R3 don't-care tail
        do_reset();
        send_char(D1); send_char(K_ALT);
        settle();
        chk(locked && rx_half == 5'b11100, "R3 tail bits ignored", {locked, rx_half}, 6'h3c);

        // R9: loopback selects transmit stream
        do_reset();
        loop_en = 1; via_tx = 1;
        send_char(D2); send_char(K_POS);
        settle();
        chk(locked, "R9 loopback source used", locked, 1);

        do_reset();
        loop_en = 0; via_tx = 1;
        send_char(D2); send_char(K_POS); send_char(D1);
        settle();
        chk(!locked, "R9 transmit stream ignored without loopback", locked, 0);

        via_tx = 0;
        send_char(K_POS);
        settle();
        chk(locked, "R9 external source used", locked, 1);

        finish_up();
    end
endmodule